// File: doc/BRIEF.md
# Control and Bulk List Scheduler

This block picks which non-periodic endpoint list a USB host controller works on next: the control list or the bulk list. It holds one grant at a time. The grant names a list and stays up until the transaction engine reports that it has served one descriptor, or that the list ran out. The scheduler then waits one idle cycle and arbitrates again.

When both lists have work, control descriptors are favoured in a programmable ratio against bulk descriptors. A list whose current pointer is zero only restarts when software has set its filled flag. The scheduler clears that flag when it grants the list. List enables take effect at frame boundaries.

The block also counts scheduling overruns in a small wrapping counter. It raises a one-cycle interrupt pulse for each overrun. Descriptor fetch, bus mastering and the transaction engine sit outside this block. Frame boundaries and overruns arrive as single-cycle pulses.

Top module: `ncs_sched`

## Requirements
- R1: When both lists are ready, `ratio_i` = r gives r+1 control grants for each bulk grant, so 0 gives 1:1 and 3 gives 4:1. `grant_blk_o` = 0 selects control and 1 selects bulk.
- R2: `ctl_en_i` and `blk_en_i` are sampled only on a `frame_i` pulse. A change between pulses has no effect until the next frame boundary.
- R3: An enabled list whose current-pointer-zero input is 1 is not granted unless its filled flag is set.
- R4: Granting a list whose filled flag is set clears that flag. The matching clear strobe (`ctl_clr_o` or `blk_clr_o`) is high for exactly the first cycle the grant is high. A set and a clear in the same cycle leave the flag set.
- R5: A write on `fill_wr_i` sets the filled flag of each list whose `fill_wdata_i` bit is 1 (bit 0 control, bit 1 bulk). A 0 bit leaves that flag unchanged.
- R6: Each `ovr_i` pulse adds 1 to `ovr_cnt_o`, wrapping from 3 to 0, and raises `ovr_irq_o` for the following cycle only. This holds even if earlier pulses were never acknowledged.
- R7: When only one list is ready, that list is granted on every slot and the ratio is not applied.
- R8: The ratio count returns to zero on `frame_i` and whenever a bulk descriptor completes. A slot ended by `eol_i` does not count as a served control descriptor.
- R9: A grant rises on the clock edge after arbitration. It is held, with a stable list select, until `done_i` or `eol_i`, and falls on the next edge. With no ready list, `grant_vld_o` stays low.
- R10: After reset, `grant_vld_o`, both clear strobes, `ovr_cnt_o` and `ovr_irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame boundary pulse |
| ctl_en_i | input | 1 | Control list enable |
| blk_en_i | input | 1 | Bulk list enable |
| ratio_i | input | 2 | Control-to-bulk service ratio minus one |
| fill_wr_i | input | 1 | Software write strobe for the filled flags |
| fill_wdata_i | input | 2 | Filled-flag write data, bit 0 control, bit 1 bulk |
| ctl_ptr_zero_i | input | 1 | Control current pointer is zero |
| blk_ptr_zero_i | input | 1 | Bulk current pointer is zero |
| done_i | input | 1 | Granted list served one descriptor |
| eol_i | input | 1 | Granted list reached its end |
| ovr_i | input | 1 | Scheduling overrun event |
| grant_vld_o | output | 1 | A list is granted |
| grant_blk_o | output | 1 | Granted list, 0 control, 1 bulk |
| ctl_clr_o | output | 1 | Control filled flag cleared this cycle |
| blk_clr_o | output | 1 | Bulk filled flag cleared this cycle |
| ovr_cnt_o | output | 2 | Overrun counter |
| ovr_irq_o | output | 1 | Overrun interrupt pulse |

## Verification
A grant, together with any clear strobe, is due one edge after the cycle where a list becomes ready while no grant is held. It falls one edge after `done_i` or `eol_i`, and the next grant follows one edge later. Overrun count and interrupt are due one edge after `ovr_i`. Enable changes become visible one edge after the frame pulse, then take a further edge to show on the grant. The bench drives inputs on falling edges and reads outputs on the next falling edge. Grant waits poll on falling edges up to a bound, so every sample lands half a period after the edge that produced it.

// File: rtl/ncs_pkg.sv
package ncs_pkg;
  localparam int unsigned NLISTS  = 2;
  localparam int unsigned RATIO_W = 2;
  localparam int unsigned OVR_W   = 2;

  typedef enum logic {
    SEL_CTL = 1'b0,
    SEL_BLK = 1'b1
  } list_sel_e;
endpackage

// File: rtl/ncs_list_state.sv
module ncs_list_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic ptr_zero_i,
  output logic rdy_o,
  output logic fill_o
);
  logic en_q, fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      fill_q <= 1'b0;
    end else begin
      if (frame_i) en_q <= en_i;
      // a new software set outranks the hardware clear
      if (set_i)      fill_q <= 1'b1;
      else if (clr_i) fill_q <= 1'b0;
    end
  end

  assign rdy_o  = en_q && (!ptr_zero_i || fill_q);
  assign fill_o = fill_q;
endmodule

// File: rtl/ncs_ratio_ctr.sv
module ncs_ratio_ctr #(
  parameter int unsigned RATIO_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_i,
  input  logic               ctl_done_i,
  input  logic               blk_done_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               bulk_due_o
);
  localparam int unsigned CNT_W = RATIO_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1 << RATIO_W);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (frame_i || blk_done_i)         cnt_q <= '0;
    else if (ctl_done_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign bulk_due_o = cnt_q > {1'b0, ratio_i};
endmodule

// File: rtl/ncs_wrap_ctr.sv
module ncs_wrap_ctr #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;
  logic         pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (inc_i) cnt_q <= cnt_q + 1'b1;
      pulse_q <= inc_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/ncs_sched.sv
module ncs_sched
  import ncs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_i,
  input  logic               ctl_en_i,
  input  logic               blk_en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               fill_wr_i,
  input  logic [NLISTS-1:0]  fill_wdata_i,
  input  logic               ctl_ptr_zero_i,
  input  logic               blk_ptr_zero_i,
  input  logic               done_i,
  input  logic               eol_i,
  input  logic               ovr_i,
  output logic               grant_vld_o,
  output logic               grant_blk_o,
  output logic               ctl_clr_o,
  output logic               blk_clr_o,
  output logic [OVR_W-1:0]   ovr_cnt_o,
  output logic               ovr_irq_o
);
  logic [NLISTS-1:0] en_vec, zero_vec, rdy, fill, start, clr_req;
  logic              grant_vld_q, bulk_due, arb, pick_blk, fin;
  list_sel_e         grant_sel_q;
  logic [NLISTS-1:0] clr_q;

  assign en_vec   = {blk_en_i, ctl_en_i};
  assign zero_vec = {blk_ptr_zero_i, ctl_ptr_zero_i};

  for (genvar i = 0; i < NLISTS; i++) begin : g_list
    ncs_list_state u_state (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .frame_i    (frame_i),
      .en_i       (en_vec[i]),
      .set_i      (fill_wr_i && fill_wdata_i[i]),
      .clr_i      (clr_req[i]),
      .ptr_zero_i (zero_vec[i]),
      .rdy_o      (rdy[i]),
      .fill_o     (fill[i])
    );
    assign clr_req[i] = start[i] && fill[i];
  end

  assign arb      = !grant_vld_q && (|rdy);
  assign pick_blk = rdy[SEL_BLK] && (!rdy[SEL_CTL] || bulk_due);
  assign start[SEL_CTL] = arb && !pick_blk;
  assign start[SEL_BLK] = arb && pick_blk;
  assign fin      = grant_vld_q && done_i;

  ncs_ratio_ctr #(.RATIO_W(RATIO_W)) u_ratio (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .ctl_done_i (fin && grant_sel_q == SEL_CTL),
    .blk_done_i (fin && grant_sel_q == SEL_BLK),
    .ratio_i    (ratio_i),
    .bulk_due_o (bulk_due)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_vld_q <= 1'b0;
      grant_sel_q <= SEL_CTL;
      clr_q       <= '0;
    end else begin
      clr_q <= clr_req;
      if (arb) begin
        grant_vld_q <= 1'b1;
        grant_sel_q <= pick_blk ? SEL_BLK : SEL_CTL;
      end else if (done_i || eol_i) begin
        grant_vld_q <= 1'b0;
      end
    end
  end

  ncs_wrap_ctr #(.W(OVR_W)) u_ovr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (ovr_i),
    .cnt_o   (ovr_cnt_o),
    .pulse_o (ovr_irq_o)
  );

  assign grant_vld_o = grant_vld_q;
  assign grant_blk_o = (grant_sel_q == SEL_BLK);
  assign ctl_clr_o   = clr_q[SEL_CTL];
  assign blk_clr_o   = clr_q[SEL_BLK];
endmodule

// File: rtl/ncs_sched_chk.sv
module ncs_sched_chk #(
  parameter int unsigned OVR_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_i,
  input logic             eol_i,
  input logic             ovr_i,
  input logic             grant_vld_o,
  input logic             grant_blk_o,
  input logic             ctl_clr_o,
  input logic             blk_clr_o,
  input logic [OVR_W-1:0] ovr_cnt_o,
  input logic             ovr_irq_o
);
  a_r4_clr_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctl_clr_o, blk_clr_o}));

  a_r4_clr_on_grant_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_clr_o || blk_clr_o) |-> $rose(grant_vld_o) && (grant_blk_o == blk_clr_o));

  a_r6_ovr_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |=> (ovr_cnt_o == $past(ovr_cnt_o) + OVR_W'(1)) && ovr_irq_o);

  a_r6_ovr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_i |=> $stable(ovr_cnt_o) && !ovr_irq_o);

  a_r9_grant_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_vld_o && !done_i && !eol_i) |=> grant_vld_o && $stable(grant_blk_o));

  a_r9_grant_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_vld_o && (done_i || eol_i)) |=> !grant_vld_o);
endmodule

bind ncs_sched ncs_sched_chk #(.OVR_W(ncs_pkg::OVR_W)) u_chk (.*);

// File: tb/ncs_sched_bench.sv
`timescale 1ns/1ps
module ncs_sched_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 0, ctl_en_i = 0, blk_en_i = 0;
  logic [1:0] ratio_i = '0;
  logic       fill_wr_i = 0;
  logic [1:0] fill_wdata_i = '0;
  logic       ctl_ptr_zero_i = 1, blk_ptr_zero_i = 1;
  logic       done_i = 0, eol_i = 0, ovr_i = 0;
  logic       grant_vld_o, grant_blk_o, ctl_clr_o, blk_clr_o, ovr_irq_o;
  logic [1:0] ovr_cnt_o;

  int  checks = 0, errors = 0;
  bit  finished = 0;
  logic got_blk;
  bit   got_ok;

  always #2.5 clk_i = ~clk_i;

  ncs_sched u_ncs_sched (.*);

  // {ratio, slot pattern (bit s = 1 means bulk expected on slot s)}
  localparam logic [11:0] RATIO_TBL [4] = '{
    {2'd0, 10'b1010101010},
    {2'd1, 10'b0100100100},
    {2'd2, 10'b0010001000},
    {2'd3, 10'b1000010000}
  };

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_grant();
    got_ok = 0;
    for (int n = 0; n < 20; n++) begin
      if (grant_vld_o) begin got_ok = 1; break; end
      tick();
    end
    got_blk = grant_blk_o;
  endtask

  task automatic finish_slot(input bit use_eol);
    if (use_eol) eol_i = 1; else done_i = 1;
    tick();
    done_i = 0; eol_i = 0;
  endtask

  task automatic serve(input bit use_eol);
    wait_grant();
    finish_slot(use_eol);
  endtask

  task automatic pulse_frame();
    frame_i = 1; tick(); frame_i = 0;
  endtask

  task automatic drain();
    ctl_ptr_zero_i = 1; blk_ptr_zero_i = 1;
    tick();
    if (grant_vld_o) finish_slot(0);
    tick(); tick();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R10 reset values
    chk("R10 grant", grant_vld_o, 0);
    chk("R10 clr", {ctl_clr_o, blk_clr_o}, 0);
    chk("R10 ovr_cnt", ovr_cnt_o, 0);
    chk("R10 ovr_irq", ovr_irq_o, 0);
    rst_ni = 1; tick();

    // R1 ratio table
    for (int r = 0; r < 4; r++) begin
      drain();
      ratio_i = RATIO_TBL[r][11:10];
      ctl_en_i = 1; blk_en_i = 1;
      pulse_frame();
      ctl_ptr_zero_i = 0; blk_ptr_zero_i = 0;
      for (int s = 0; s < 10; s++) begin
        serve(0);
        chk($sformatf("R1 ratio=%0d slot=%0d grant", r, s), got_ok, 1);
        chk($sformatf("R1 ratio=%0d slot=%0d bulk", r, s), got_blk, RATIO_TBL[r][s]);
      end
    end

    // R9 grant falls one edge after done, idle with nothing ready
    drain();
    ratio_i = 0; pulse_frame();
    ctl_ptr_zero_i = 0;
    wait_grant();
    chk("R9 grant up", got_ok, 1);
    done_i = 1; tick(); done_i = 0;
    chk("R9 grant down after done", grant_vld_o, 0);
    ctl_ptr_zero_i = 1;
    tick(); if (grant_vld_o) finish_slot(0);
    for (int n = 0; n < 8; n++) tick();
    chk("R9 R3 idle with zero pointers", grant_vld_o, 0);

    // R5 write of 0 keeps pending flag, R4 clear strobe, R3 no restart after clear
    ctl_en_i = 0; pulse_frame();
    fill_wr_i = 1; fill_wdata_i = 2'b01; tick();
    fill_wdata_i = 2'b00; tick(); tick();
    fill_wr_i = 0; tick();
    chk("R2 disabled list not granted", grant_vld_o, 0);
    ctl_en_i = 1; pulse_frame();
    wait_grant();
    chk("R5 pending fill survives write 0", got_ok, 1);
    chk("R4 control granted", got_blk, 0);
    chk("R4 ctl clear strobe", ctl_clr_o, 1);
    chk("R4 blk clear strobe idle", blk_clr_o, 0);
    finish_slot(0);
    chk("R4 strobe one cycle", ctl_clr_o, 0);
    for (int n = 0; n < 6; n++) tick();
    chk("R4 R3 flag cleared, no restart", grant_vld_o, 0);
    fill_wr_i = 1; fill_wdata_i = 2'b10; tick(); fill_wr_i = 0;
    wait_grant();
    chk("R4 bulk granted from fill", got_blk, 1);
    chk("R4 blk clear strobe", blk_clr_o, 1);
    finish_slot(0);

    // R2 enable change waits for frame, R7 single ready list every slot
    drain();
    ratio_i = 3; ctl_en_i = 1; blk_en_i = 1; pulse_frame();
    ctl_ptr_zero_i = 0; blk_ptr_zero_i = 0;
    serve(0);
    chk("R2 first slot control", got_blk, 0);
    ctl_en_i = 0;
    serve(0);
    chk("R2 control still enabled before frame", got_blk, 0);
    wait_grant();
    pulse_frame();
    finish_slot(0);
    for (int s = 0; s < 4; s++) begin
      serve(0);
      chk($sformatf("R7 R2 bulk only slot=%0d", s), got_blk, 1);
    end

    // R8 eol does not count
    drain();
    ratio_i = 0; ctl_en_i = 1; blk_en_i = 1; pulse_frame();
    ctl_ptr_zero_i = 0; blk_ptr_zero_i = 0;
    serve(1);
    chk("R8 eol slot control", got_blk, 0);
    serve(0);
    chk("R8 control again after eol", got_blk, 0);
    serve(0);
    chk("R8 bulk after counted control", got_blk, 1);

    // R8 frame resets ratio count
    drain();
    ratio_i = 1; pulse_frame();
    ctl_ptr_zero_i = 0; blk_ptr_zero_i = 0;
    serve(0);
    chk("R8 pre-frame control", got_blk, 0);
    wait_grant();
    pulse_frame();
    finish_slot(0);
    serve(0);
    chk("R8 post-frame control 1", got_blk, 0);
    serve(0);
    chk("R8 post-frame bulk", got_blk, 1);
    drain();

    // R6 overrun counter wrap and pulse
    for (int k = 1; k <= 5; k++) begin
      ovr_i = 1; tick(); ovr_i = 0;
      chk($sformatf("R6 ovr count k=%0d", k), ovr_cnt_o, k % 4);
      chk($sformatf("R6 ovr irq k=%0d", k), ovr_irq_o, 1);
      tick();
      chk($sformatf("R6 irq drops k=%0d", k), ovr_irq_o, 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule